// File: doc/BRIEF.md
# Special-Register Result Upload Controller

This controller copies a bank of 16-bit special-purpose registers out to a fixed window in a shared byte-wide memory. The bank holds the best motion-vector coordinates, the matching SAD value, the block size, the search-area size and the image dimensions. The main control unit pulses a trigger. The controller then takes a snapshot of the whole bank, requests ownership of the shared memory bus and waits for the grant. After the grant it stores the bank one byte per granted cycle into consecutive locations that start at a base address (0xFFFF0 by default).

The host watches a level output that changes state once for every byte stored. From it the host can tell that a new byte has landed in the reserved window. When the last byte is written, the controller drops its bus request and raises a one-cycle finished pulse. It accepts the next trigger only after that pulse. If the grant is withdrawn during a transfer, the transfer pauses and resumes at the same byte.

Top module: `spr_upload_ctrl`

## Requirements
- R1: After reset, bus_req_o, store_o, done_o and finish_o are all 0.
- R2: A start_i seen high in the idle state raises bus_req_o from the next cycle. bus_req_o stays high until the cycle in which the last byte is stored, and no byte is stored before bus_gnt_i is high.
- R3: Byte k (k = 0..15) is stored at address 0xFFFF0 + k, in increasing k. At most one byte is stored per cycle, in a cycle where bus_req_o and bus_gnt_i are both high.
- R4: spr_i carries register i in bits [16i+15:16i]. Byte 2i is bits [16i+7:16i] of register i (the low byte) and byte 2i+1 is bits [16i+15:16i+8] (the high byte).
- R5: store_o is 1 (store) exactly in the cycles where a byte is written and 0 (load) in every other cycle, including after the upload ends.
- R6: done_o inverts in the cycle after each stored byte and holds its level otherwise.
- R7: The stored data is the value of spr_i in the cycle the trigger was accepted. Later changes to spr_i during that upload have no effect on the bytes written.
- R8: If bus_gnt_i is low during a transfer, nothing is stored and the next byte index is kept. The transfer continues with that byte once the grant returns.
- R9: In the cycle after the sixteenth byte, finish_o is high for exactly one cycle and bus_req_o is 0.
- R10: start_i is ignored while an upload is in progress, including the finish_o cycle. It is accepted again from the cycle after finish_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Upload trigger from the main control unit |
| spr_i | input | 128 | Flat special-register bank, register i at bits [16i+15:16i] |
| bus_req_o | output | 1 | Request for the shared memory bus |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| mem_addr_o | output | 20 | Byte address in the reserved window |
| mem_wdata_o | output | 8 | Byte being stored |
| store_o | output | 1 | 1 = store cycle, 0 = load (idle) |
| done_o | output | 1 | Level that inverts once per stored byte |
| finish_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The end of one upload (the finish_o pulse) and the acceptance of a new trigger can fall in the same cycle. The bench provokes this by raising start_i exactly in the cycle where finish_o is high. It then requires that bus_req_o stays low for several cycles and that no byte is stored. A second collision pairs a withdrawn grant with a pending byte: the grant is dropped mid-transfer, and the scoreboard requires that the paused byte appears next, with the correct address, and that done_o does not move while the transfer waits.

// File: rtl/upl_pkg.sv
package upl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2,
      ST_FIN  = 2'd3
   } upl_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/upl_shadow_bank.sv
module upl_shadow_bank #(
   parameter int NUM_REGS = 8,
   parameter int WORD_W   = 16,
   localparam int BANK_W  = NUM_REGS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [BANK_W-1:0] regs_i,
   output logic [BANK_W-1:0] shadow_o
);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (cap_i) begin
            word_q <= regs_i[r*WORD_W +: WORD_W];
         end
      end
      assign shadow_o[r*WORD_W +: WORD_W] = word_q;
   end

endmodule

// File: rtl/upl_byte_select.sv
module upl_byte_select #(
   parameter int NUM_REGS       = 8,
   parameter int WORD_W         = 16,
   parameter int BYTE_W         = 8,
   parameter bit LOW_BYTE_FIRST = 1'b1,
   localparam int BANK_W        = NUM_REGS * WORD_W,
   localparam int LANES         = WORD_W / BYTE_W,
   localparam int NUM_BYTES     = NUM_REGS * LANES,
   localparam int CNT_W         = $clog2(NUM_BYTES)
) (
   input  logic [BANK_W-1:0] shadow_i,
   input  logic [CNT_W-1:0]  idx_i,
   output logic [BYTE_W-1:0] byte_o
);

   logic [BYTE_W-1:0] byte_arr [NUM_BYTES];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         if (LOW_BYTE_FIRST) begin : g_lo
            assign byte_arr[r*LANES + l] = shadow_i[r*WORD_W + l*BYTE_W +: BYTE_W];
         end else begin : g_hi
            assign byte_arr[r*LANES + l] =
               shadow_i[r*WORD_W + (LANES-1-l)*BYTE_W +: BYTE_W];
         end
      end
   end

   always_comb begin
      byte_o = '0;
      for (int k = 0; k < NUM_BYTES; k++) begin
         if (idx_i == CNT_W'(k)) begin
            byte_o = byte_arr[k];
         end
      end
   end

endmodule

// File: rtl/upl_sequencer.sv
module upl_sequencer
   import upl_pkg::*;
#(
   parameter int NUM_BYTES = 16,
   localparam int CNT_W    = $clog2(NUM_BYTES),
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BYTES - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             gnt_i,
   output logic             accept_o,
   output logic             req_o,
   output logic             wr_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             done_o,
   output logic             fin_o
);

   upl_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             done_q;
   logic             last_byte;

   assign accept_o  = (state_q == ST_IDLE) && start_i;
   assign wr_o      = (state_q == ST_XFER) && gnt_i;
   assign last_byte = wr_o && (cnt_q == LAST_IDX);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_REQ;
               cnt_d   = '0;
            end
         end
         ST_REQ: begin
            if (gnt_i) begin
               state_d = ST_XFER;
            end
         end
         ST_XFER: begin
            if (wr_o) begin
               if (last_byte) begin
                  state_d = ST_FIN;
                  cnt_d   = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         ST_FIN: begin
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (wr_o) begin
            done_q <= ~done_q;
         end
      end
   end

   assign req_o  = (state_q == ST_REQ) || (state_q == ST_XFER);
   assign fin_o  = (state_q == ST_FIN);
   assign cnt_o  = cnt_q;
   assign done_o = done_q;

endmodule

// File: rtl/spr_upload_ctrl.sv
module spr_upload_ctrl
   import upl_pkg::*;
#(
   parameter int NUM_REGS       = 8,
   parameter int WORD_W         = 16,
   parameter int BYTE_W         = 8,
   parameter int ADDR_W         = 20,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 20'hFFFF0,
   parameter bit LOW_BYTE_FIRST = 1'b1,
   localparam int BANK_W        = NUM_REGS * WORD_W,
   localparam int LANES         = WORD_W / BYTE_W,
   localparam int NUM_BYTES     = NUM_REGS * LANES,
   localparam int CNT_W         = $clog2(NUM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [BANK_W-1:0] spr_i,
   output logic              bus_req_o,
   input  logic              bus_gnt_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [BYTE_W-1:0] mem_wdata_o,
   output logic              store_o,
   output logic              done_o,
   output logic              finish_o
);

   if (BYTE_W < 1 || WORD_W % BYTE_W != 0) begin : g_chk_lane
      $error("WORD_W must be a whole multiple of BYTE_W");
   end
   if (!is_pow2(LANES)) begin : g_chk_pow2
      $error("WORD_W/BYTE_W must be a power of two");
   end
   if (NUM_BYTES < 2) begin : g_chk_count
      $error("at least two bytes must be uploaded");
   end
   if ((longint'(BASE_ADDR) + longint'(NUM_BYTES)) > (longint'(1) << ADDR_W)) begin : g_chk_win
      $error("reserved window does not fit in the address space");
   end

   logic              accept;
   logic              wr;
   logic [CNT_W-1:0]  idx;
   logic [BANK_W-1:0] shadow;
   logic [BYTE_W-1:0] cur_byte;

   upl_sequencer #(
      .NUM_BYTES (NUM_BYTES)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .gnt_i    (bus_gnt_i),
      .accept_o (accept),
      .req_o    (bus_req_o),
      .wr_o     (wr),
      .cnt_o    (idx),
      .done_o   (done_o),
      .fin_o    (finish_o)
   );

   upl_shadow_bank #(
      .NUM_REGS (NUM_REGS),
      .WORD_W   (WORD_W)
   ) shadow_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_i    (accept),
      .regs_i   (spr_i),
      .shadow_o (shadow)
   );

   upl_byte_select #(
      .NUM_REGS       (NUM_REGS),
      .WORD_W         (WORD_W),
      .BYTE_W         (BYTE_W),
      .LOW_BYTE_FIRST (LOW_BYTE_FIRST)
   ) bsel_i (
      .shadow_i (shadow),
      .idx_i    (idx),
      .byte_o   (cur_byte)
   );

   assign mem_addr_o  = BASE_ADDR + ADDR_W'(idx);
   assign mem_wdata_o = cur_byte;
   assign store_o     = wr;

endmodule

// File: rtl/upl_checker.sv
module upl_checker #(
   parameter int NUM_BYTES = 16,
   parameter int ADDR_W    = 20,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 20'hFFFF0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              bus_req_o,
   input logic              bus_gnt_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              store_o,
   input logic              done_o,
   input logic              finish_o
);

   localparam logic [ADDR_W:0] TOP_ADDR = {1'b0, BASE_ADDR} + (ADDR_W+1)'(NUM_BYTES - 1);

   // R3, R5: a store only with request and grant both high
   a_r3_store_granted: assert property (@(posedge clk) disable iff (!rst_n)
      store_o |-> (bus_req_o && bus_gnt_i));

   // R3: store address inside the reserved window
   a_r3_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
      store_o |-> (mem_addr_o >= BASE_ADDR && {1'b0, mem_addr_o} <= TOP_ADDR));

   // R6: done inverts after each store
   a_r6_done_flips: assert property (@(posedge clk) disable iff (!rst_n)
      store_o |=> (done_o != $past(done_o)));

   // R6: done holds without a store
   a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !store_o |=> $stable(done_o));

   // R2, R8: request held while the grant is missing
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_gnt_i) |=> bus_req_o);

   // R2: trigger accepted in idle raises the request
   a_r2_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !bus_req_o && !finish_o) |=> bus_req_o);

   // R9: finish pulse lasts one cycle with the request released
   a_r9_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o |=> !finish_o);
   a_r9_fin_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o |-> (!bus_req_o && !store_o));

   // R10: trigger in the finish cycle does not start a new upload
   a_r10_fin_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o |=> !bus_req_o);

endmodule

bind spr_upload_ctrl upl_checker #(
   .NUM_BYTES (NUM_BYTES),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .bus_req_o  (bus_req_o),
   .bus_gnt_i  (bus_gnt_i),
   .mem_addr_o (mem_addr_o),
   .store_o    (store_o),
   .done_o     (done_o),
   .finish_o   (finish_o)
);

// File: tb/spr_upload_ctrl_tb_top.sv
`timescale 1ns/1ps
module spr_upload_ctrl_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] spr = '0;
   logic         gnt = 1'b0;
   logic         req, store, done, fin;
   logic [19:0]  addr;
   logic [7:0]   wdata;

   int checks = 0;
   int failures = 0;
   int gnt_delay = 0;
   int stall_at = -1;
   int stall_len = 0;
   int wait_cnt = 0;
   int granted = 0;
   int stall_left = 0;
   int writes = 0;
   int up_bytes = 0;
   int uploads = 0;
   bit in_up = 1'b0;
   bit expect_fin = 1'b0;
   bit mon_on = 1'b0;
   int cycles = 0;

   logic [27:0] sb_q [$];

   always #10 clk = ~clk;

   spr_upload_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .spr_i       (spr),
      .bus_req_o   (req),
      .bus_gnt_i   (gnt),
      .mem_addr_o  (addr),
      .mem_wdata_o (wdata),
      .store_o     (store),
      .done_o      (done),
      .finish_o    (fin)
   );

   task automatic check(input bit ok, input string req_tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   // grant model
   always @(negedge clk) begin
      if (!req) begin
         gnt <= 1'b0;
         wait_cnt <= 0;
         granted <= 0;
         stall_left <= 0;
      end else if (wait_cnt < gnt_delay) begin
         gnt <= 1'b0;
         wait_cnt <= wait_cnt + 1;
      end else if (stall_left > 0) begin
         gnt <= 1'b0;
         stall_left <= stall_left - 1;
      end else if (granted == stall_at && stall_len > 0 && gnt) begin
         gnt <= 1'b0;
         stall_left <= stall_len - 1;
         granted <= granted + 1;
      end else begin
         gnt <= 1'b1;
         if (gnt) granted <= granted + 1;
      end
   end

   // monitor and scoreboard
   always @(negedge clk) begin
      #5;
      if (mon_on) begin
         check(done == writes[0], "R6", "done parity", done, writes[0]);
         check(fin == expect_fin, "R9", "finish pulse", fin, expect_fin);
         if (fin) begin
            check(!req, "R9", "req at finish", req, 0);
            in_up = 1'b0;
            uploads++;
         end
         expect_fin = 1'b0;
         if (in_up && !fin) check(req, "R2", "req held", req, 1);
         if (store) begin
            check(gnt, "R5", "store without grant", gnt, 1);
            if (sb_q.size() == 0) begin
               check(1'b0, "R10", "unexpected store", addr, 0);
            end else begin
               logic [27:0] e;
               e = sb_q.pop_front();
               check(addr == e[27:8], "R3", "address", addr, e[27:8]);
               check(wdata == e[7:0], "R4", "data", wdata, e[7:0]);
            end
            writes++;
            up_bytes++;
            if (up_bytes == 16) begin
               up_bytes = 0;
               expect_fin = 1'b1;
            end
         end else begin
            if (!req) check(!store, "R5", "load when idle", store, 0);
         end
      end
   end

   task automatic push_expect(input logic [127:0] v);
      for (int k = 0; k < 16; k++) begin
         logic [7:0] b;
         b = v[(k/2)*16 + (k%2)*8 +: 8];
         sb_q.push_back({20'hFFFF0 + 20'(k), b});
      end
   endtask

   task automatic run_upload(input logic [127:0] v, input int dly, input int st_at,
                             input int st_len, input bit disturb);
      int start_count;
      gnt_delay = dly;
      stall_at = st_at;
      stall_len = st_len;
      push_expect(v);
      start_count = uploads;
      @(negedge clk);
      spr = v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      in_up = 1'b1;
      if (disturb) begin
         // R7: bank changes after the capture
         spr = ~v;
         repeat (dly + 3) @(negedge clk);
         // R10: trigger while busy is ignored
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (uploads == start_count) @(negedge clk);
      #6;
      check(sb_q.size() == 0, "R3", "all bytes seen", sb_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!req, "R1", "req in reset", req, 0);
      check(!store, "R1", "store in reset", store, 0);
      check(!done, "R1", "done in reset", done, 0);
      check(!fin, "R1", "finish in reset", fin, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      repeat (2) @(negedge clk);
      #6;
      check(!req && !fin, "R1", "idle after reset", {req, fin}, 0);

      // R2 R3 R4: immediate grant
      run_upload(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 0, -1, 0, 1'b0);
      // R2: delayed grant
      run_upload(128'hA5A5_5A5A_FFFF_0000_1111_2222_8001_7FFE, 5, -1, 0, 1'b0);
      // R8: grant withdrawn mid-transfer
      run_upload(128'h1357_9BDF_2468_ACE0_DEAD_BEEF_CAFE_F00D, 1, 6, 3, 1'b0);
      // R7 R10: bank disturbed and extra trigger during transfer
      run_upload(128'h0F0F_F0F0_00FF_FF00_3C3C_C3C3_9999_6666, 2, 9, 2, 1'b1);

      // R10: trigger in the finish cycle
      push_expect(128'h0000_0000_0000_0000_0000_0000_0000_00FF);
      gnt_delay = 0; stall_at = -1; stall_len = 0;
      begin
         int c0;
         c0 = uploads;
         @(negedge clk);
         spr = 128'hFF;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         in_up = 1'b1;
         while (!fin) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         for (int i = 0; i < 6; i++) begin
            #6;
            check(!req, "R10", "start in finish cycle ignored", req, 0);
            @(negedge clk);
         end
         check(uploads == c0 + 1, "R10", "upload count", uploads, c0 + 1);
      end

      // R10: accepted again after finish
      run_upload(128'h7777_6666_5555_4444_3333_2222_1111_0000, 0, -1, 0, 1'b0);
      repeat (3) @(negedge clk);
      #6;
      check(!store && !req, "R5", "load state after upload", {store, req}, 0);
      finish_run();
   end

endmodule